// File: doc/BRIEF.md
# Photon Counter Cell with Serial Readout

This block is one channel of a multichannel event counter. A single 16-bit register does three jobs. Mode pins select the job. In normal counting it counts the pulses from the channel's comparator. In readout it acts as a shift register, and cells placed end to end form one long serial chain. In test it counts pulses on a shared test pin, or it shifts only when a run strobe arms it. A sticky active-low overflow flag records a counter wrap. This flag is passed along an AND chain, so the last cell of the chain shows whether any channel has overflowed.

Every strobe and level input is asynchronous. Each passes through a two-flop synchronizer on a fast system clock, and the block acts on the edges of the resulting levels. The system clock must run at least four times faster than the fastest event or readout strobe. The serial ports are split into a data-in, a data-out and an output-enable signal on each side, so the pad ring can build the bidirectional pins. Readout empties the register. A reader that wants to keep the value feeds each bit it reads back into the serial input.

Top module: `pcnt_cell`

## Requirements
- R1: With mode pins test=0 and read=0, each complete comparator pulse (low, high, low) adds one to the count. The increment happens at the pulse's falling edge.
- R2: With test=0 and read=1, each complete active-low shift-clock pulse (high, low, high) shifts the register by exactly one position. The shift happens at the pulse's rising edge.
- R3: A shift moves the register toward its most significant bit and loads the serial input into bit 0. The driven serial output always carries bit 15, so data leaves the cell MSB first.
- R4: The direction pin selects the serial path. With direction=0, the input comes from the down port and the up port drives its output with up_oe=1. With direction=1, the input comes from the up port and the down port drives. Both output enables are 0 whenever read=0.
- R5: With test=1 and read=0, each active-low pulse on the common test pin adds one at its rising end. Comparator pulses are ignored.
- R6: With test=1 and read=1, a shift-clock pulse shifts only if a full run pulse (high, low) ended before the shift clock fell. A shift-clock pulse with no run pulse before it does not shift. A shift-clock pulse that falls while run is still high does not shift.
- R7: ovf_n_o is high until an increment carries the count from 0xFFFF to 0x0000. It then goes low, and stays low through further counting until the next shift.
- R8: In counting mode, the shift clock, common pin, direction pin and serial inputs leave the count unchanged. In readout mode, comparator pulses leave it unchanged.
- R9: Shifting in sixteen 0 bits clears the register. Shifting in sixteen 1 bits presets it to 0xFFFF. Any 16-bit value can be loaded MSB first.
- R10: ovf_chain_o is the AND of ovf_prev_i and ovf_n_o. A chain whose first cell has ovf_prev_i tied high therefore ends low if any cell has overflowed.
- R11: If the shift clock is already low when readout mode is entered, its next rising edge causes no shift. The first shift needs a full high-low-high pulse.
- R12: After reset the count is 0, ovf_n_o is 1 and both output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the fastest strobe |
| rst_n | input | 1 | Active-low asynchronous reset |
| hit_i | input | 1 | Comparator pulse, active high |
| tst_pin_i | input | 1 | Shared test pulse, active low, idles high |
| rd_sel_i | input | 1 | Mode pin: 1 selects shifting, 0 selects counting |
| tst_en_i | input | 1 | Mode pin: 1 selects the test variants |
| sclk_i | input | 1 | Shift clock, active-low pulse, idles high |
| dir_i | input | 1 | Serial direction select |
| run_i | input | 1 | Run strobe used to arm a shift in test readout |
| up_in_i | input | 1 | Serial data arriving on the up side |
| dn_in_i | input | 1 | Serial data arriving on the down side |
| ovf_prev_i | input | 1 | Overflow chain input from the previous cell, active low |
| up_out_o | output | 1 | Serial data driven on the up side |
| up_oe_o | output | 1 | Up-side output enable |
| dn_out_o | output | 1 | Serial data driven on the down side |
| dn_oe_o | output | 1 | Down-side output enable |
| ovf_n_o | output | 1 | Local sticky overflow, active low |
| ovf_chain_o | output | 1 | Overflow chain output to the next cell, active low |

## Verification
The bench reads the count back through the serial path only, reloading each bit as it reads it. It targets the following corner cases:
- The carry from 0xFFFE through 0xFFFF into zero. A counter that loses the sticky flag, or that clears it on the next increment, shows ovf_n_o high one pulse too early.
- A shift clock that is already low when readout starts. A design with no arming step shifts once on the release, and the serial output changes bit.
- In test readout, a shift clock with no run pulse before it, and one that overlaps the run pulse. A design that accepts either case moves the register.
- Stray activity on the pins that should be ignored in each mode. It is checked by reading back a value loaded before the activity.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  // Mode encoding is {test, read}
  typedef enum logic [1:0] {
    M_COUNT  = 2'b00,
    M_READ   = 2'b01,
    M_TCOUNT = 2'b10,
    M_TREAD  = 2'b11
  } pcnt_mode_e;
endpackage

// File: rtl/pcnt_sync.sv
module pcnt_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pcnt_edge.sv
module pcnt_edge #(
  parameter int W = 1,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/pcnt_ctl.sv
module pcnt_ctl
  import pcnt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_lvl,
  input  logic te_lvl,
  input  logic run_lvl,
  input  logic hit_fall,
  input  logic tst_rise,
  input  logic sclk_fall,
  input  logic sclk_rise,
  input  logic run_fall,
  output logic cnt_ev,
  output logic shift_ev
);
  pcnt_mode_e mode, mode_q;
  logic armed_q, run_seen_q, mode_steady;

  assign mode = pcnt_mode_e'({te_lvl, rd_lvl});
  assign mode_steady = (mode == mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= M_COUNT;
      armed_q    <= 1'b0;
      run_seen_q <= 1'b0;
    end else begin
      mode_q <= mode;
      if (!mode_steady) begin
        armed_q    <= 1'b0;
        run_seen_q <= 1'b0;
      end else begin
        unique case (mode)
          M_READ: begin
            if (sclk_fall)      armed_q <= 1'b1;
            else if (sclk_rise) armed_q <= 1'b0;
          end
          M_TREAD: begin
            if (run_fall) run_seen_q <= 1'b1;
            if (sclk_fall) begin
              armed_q    <= run_seen_q && !run_lvl;
              run_seen_q <= 1'b0;
            end else if (sclk_rise) begin
              armed_q <= 1'b0;
            end
          end
          default: begin
            armed_q    <= 1'b0;
            run_seen_q <= 1'b0;
          end
        endcase
      end
    end
  end

  assign cnt_ev   = mode_steady && ((mode == M_COUNT && hit_fall) ||
                                    (mode == M_TCOUNT && tst_rise));
  assign shift_ev = mode_steady && (mode == M_READ || mode == M_TREAD) &&
                    sclk_rise && armed_q;
endmodule

// File: rtl/pcnt_cell.sv
module pcnt_cell #(
  parameter int CNT_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic tst_pin_i,
  input  logic rd_sel_i,
  input  logic tst_en_i,
  input  logic sclk_i,
  input  logic dir_i,
  input  logic run_i,
  input  logic up_in_i,
  input  logic dn_in_i,
  input  logic ovf_prev_i,
  output logic up_out_o,
  output logic up_oe_o,
  output logic dn_out_o,
  output logic dn_oe_o,
  output logic ovf_n_o,
  output logic ovf_chain_o
);
  // synchronised input bundle layout
  localparam int I_HIT = 0, I_TST = 1, I_RD = 2, I_TE = 3, I_SCLK = 4;
  localparam int I_DIR = 5, I_RUN = 6, I_UP = 7, I_DN = 8;
  localparam int NIN = 9;
  localparam logic [NIN-1:0] IN_IDLE = NIN'((1 << I_TST) | (1 << I_SCLK));
  // pulse strobes: {run, sclk, tst, hit}
  localparam int NP = 4;
  localparam logic [NP-1:0] P_IDLE = 4'b0110;

  function automatic logic [CNT_W-1:0] f_incr(input logic [CNT_W-1:0] v);
    return v + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] f_shift(input logic [CNT_W-1:0] v, input logic b);
    return {v[CNT_W-2:0], b};
  endfunction

  function automatic logic f_at_max(input logic [CNT_W-1:0] v);
    return &v;
  endfunction

  logic [NIN-1:0] raw_in, syn;
  logic [NP-1:0]  p_rise, p_fall;
  logic [CNT_W-1:0] count_q;
  logic ovf_q, cnt_ev, shift_ev, wrap_ev, ser_in, msb;

  assign raw_in = {dn_in_i, up_in_i, run_i, dir_i, sclk_i, tst_en_i, rd_sel_i, tst_pin_i, hit_i};

  pcnt_sync #(.W(NIN), .STAGES(SYNC_N), .RST_VAL(IN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
  );

  pcnt_edge #(.W(NP), .IDLE(P_IDLE)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .lvl({syn[I_RUN], syn[I_SCLK], syn[I_TST], syn[I_HIT]}),
    .rise(p_rise), .fall(p_fall)
  );

  pcnt_ctl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .rd_lvl(syn[I_RD]), .te_lvl(syn[I_TE]), .run_lvl(syn[I_RUN]),
    .hit_fall(p_fall[0]), .tst_rise(p_rise[1]),
    .sclk_fall(p_fall[2]), .sclk_rise(p_rise[2]), .run_fall(p_fall[3]),
    .cnt_ev(cnt_ev), .shift_ev(shift_ev)
  );

  assign ser_in  = syn[I_DIR] ? syn[I_UP] : syn[I_DN];
  assign wrap_ev = cnt_ev && f_at_max(count_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else if (shift_ev) begin
      count_q <= f_shift(count_q, ser_in);
      ovf_q   <= 1'b0;
    end else if (cnt_ev) begin
      count_q <= f_incr(count_q);
      if (wrap_ev) ovf_q <= 1'b1;
    end
  end

  assign msb         = count_q[CNT_W-1];
  assign up_oe_o     = syn[I_RD] && !syn[I_DIR];
  assign dn_oe_o     = syn[I_RD] &&  syn[I_DIR];
  assign up_out_o    = up_oe_o && msb;
  assign dn_out_o    = dn_oe_o && msb;
  assign ovf_n_o     = !ovf_q;
  assign ovf_chain_o = ovf_prev_i && !ovf_q;
endmodule

// File: rtl/pcnt_cell_chk.sv
module pcnt_cell_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count,
  input logic             ovf,
  input logic             cnt_ev,
  input logic             shift_ev,
  input logic             wrap_ev,
  input logic             sin,
  input logic             ovf_prev_i,
  input logic             ovf_chain_o,
  input logic             up_oe_o,
  input logic             dn_oe_o
);
  // R1: a non-wrapping count event adds exactly one
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ev && !wrap_ev |=> count == CNT_W'($past(count) + 1'b1));
  // R2: counting and shifting never coincide
  p_one_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_ev && shift_ev));
  // R3: shift moves toward the MSB and loads the serial input at bit 0
  p_shift_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ev |=> count == {$past(count[CNT_W-2:0]), $past(sin)});
  // R4: at most one side drives
  p_one_driver_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_oe_o && dn_oe_o));
  // R7: a wrap lands on zero with the flag raised
  p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> (count == '0) && ovf);
  // R7: the flag holds until a shift
  p_ovf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !shift_ev |=> ovf);
  // R7: the flag rises only after a wrap
  p_ovf_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(wrap_ev));
  // R10: chain output low whenever upstream or local flag is low
  p_chain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_prev_i || ovf) |-> !ovf_chain_o);
endmodule

bind pcnt_cell pcnt_cell_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .count(count_q), .ovf(ovf_q),
  .cnt_ev(cnt_ev), .shift_ev(shift_ev), .wrap_ev(wrap_ev), .sin(ser_in),
  .ovf_prev_i(ovf_prev_i), .ovf_chain_o(ovf_chain_o),
  .up_oe_o(up_oe_o), .dn_oe_o(dn_oe_o)
);

// File: tb/pcnt_cell_tb.sv
module pcnt_cell_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hit = 0, tst = 1, rd = 0, te = 0, sclk = 1, dir = 0, run = 0;
  logic up_in = 0, dn_in = 0, ovf_prev = 1;
  logic up_out, up_oe, dn_out, dn_oe, ovf_n, chain;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pcnt_cell u_dut (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .tst_pin_i(tst), .rd_sel_i(rd),
    .tst_en_i(te), .sclk_i(sclk), .dir_i(dir), .run_i(run),
    .up_in_i(up_in), .dn_in_i(dn_in), .ovf_prev_i(ovf_prev),
    .up_out_o(up_out), .up_oe_o(up_oe), .dn_out_o(dn_out), .dn_oe_o(dn_oe),
    .ovf_n_o(ovf_n), .ovf_chain_o(chain)
  );

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic obit();
    return dir ? dn_out : up_out;
  endfunction

  task automatic drive_sin(input logic b);
    if (dir) up_in = b; else dn_in = b;
  endtask

  task automatic set_mode(input logic t, input logic r);
    idle(1); te = t; rd = r; idle(6);
  endtask

  task automatic pulse_hit();  hit = 1; idle(4); hit = 0; idle(4); endtask
  task automatic pulse_com();  tst = 0; idle(4); tst = 1; idle(4); endtask
  task automatic pulse_sclk(); sclk = 0; idle(4); sclk = 1; idle(6); endtask
  task automatic pulse_run();  run = 1; idle(4); run = 0; idle(4); endtask

  task automatic load_val(input logic [15:0] v);
    set_mode(0, 1);
    for (int i = 15; i >= 0; i--) begin
      drive_sin(v[i]); idle(4); pulse_sclk();
    end
  endtask

  task automatic read_val(output logic [15:0] v);
    set_mode(0, 1);
    for (int i = 15; i >= 0; i--) begin
      logic b;
      b = obit(); v[i] = b; drive_sin(b); idle(4); pulse_sclk();
    end
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R12 ovf_n", 16'(ovf_n), 16'd1);
    check("R12 chain", 16'(chain), 16'd1);
    check("R12 oe", 16'({up_oe, dn_oe}), 16'd0);
    read_val(v);
    check("R12 count", v, 16'h0000);
  endtask

  task automatic t_count();
    logic [15:0] v;
    set_mode(0, 0);
    check("R4 oe off in count", 16'({up_oe, dn_oe}), 16'd0);
    for (int i = 0; i < 5; i++) pulse_hit();
    read_val(v);
    check("R1 five pulses", v, 16'd5);
    check("R4 up drives", 16'({up_oe, dn_oe}), 16'b10);
    read_val(v);
    check("R1 readback kept", v, 16'd5);
  endtask

  task automatic t_load();
    logic [15:0] v;
    load_val(16'hFFFF); read_val(v);
    check("R9 preset", v, 16'hFFFF);
    load_val(16'h0000); read_val(v);
    check("R9 clear", v, 16'h0000);
  endtask

  task automatic t_msb();
    load_val(16'h4001);
    check("R3 first bit is bit15", 16'(obit()), 16'd0);
    pulse_sclk();
    check("R3 next bit is bit14", 16'(obit()), 16'd1);
  endtask

  task automatic t_dir();
    logic [15:0] v;
    idle(1); dir = 1; idle(6);
    set_mode(0, 1);
    check("R4 down drives", 16'({up_oe, dn_oe}), 16'b01);
    load_val(16'hA5C3); read_val(v);
    check("R4 reverse path", v, 16'hA5C3);
    idle(1); dir = 0; idle(6);
  endtask

  task automatic t_ignore();
    logic [15:0] v;
    load_val(16'h0007);
    set_mode(0, 0);
    pulse_sclk(); pulse_com();
    dir = 1; idle(4); dir = 0; idle(4);
    up_in = 1; dn_in = 1; idle(4); up_in = 0; dn_in = 0; idle(4);
    read_val(v);
    check("R8 count mode ignores", v, 16'h0007);
    load_val(16'h1234);
    pulse_hit(); pulse_hit(); pulse_hit();
    read_val(v);
    check("R8 read mode ignores hits", v, 16'h1234);
  endtask

  task automatic t_test_count();
    logic [15:0] v;
    load_val(16'h0000);
    set_mode(1, 0);
    pulse_com(); pulse_com(); pulse_com();
    pulse_hit(); pulse_hit();
    read_val(v);
    check("R5 common counted, hit ignored", v, 16'd3);
  endtask

  task automatic t_test_read();
    load_val(16'hAAAA);
    set_mode(1, 1);
    check("R6 start bit", 16'(obit()), 16'd1);
    pulse_sclk();
    check("R6 no run no shift", 16'(obit()), 16'd1);
    pulse_run(); pulse_sclk();
    check("R6 run then sclk shifts", 16'(obit()), 16'd0);
    run = 1; idle(4); sclk = 0; idle(4); run = 0; idle(4); sclk = 1; idle(6);
    check("R6 overlap no shift", 16'(obit()), 16'd0);
    pulse_run(); pulse_sclk();
    check("R6 second armed shift", 16'(obit()), 16'd1);
  endtask

  task automatic t_spurious();
    load_val(16'h8000);
    set_mode(0, 0);
    sclk = 0; idle(6);
    set_mode(0, 1);
    sclk = 1; idle(6);
    check("R11 no shift on release", 16'(obit()), 16'd1);
    pulse_sclk();
    check("R11 full pulse shifts", 16'(obit()), 16'd0);
  endtask

  task automatic t_ovf();
    logic [15:0] v;
    ovf_prev = 1;
    load_val(16'hFFFE);
    set_mode(0, 0);
    pulse_hit();
    check("R7 no flag at max", 16'(ovf_n), 16'd1);
    pulse_hit();
    check("R7 flag on wrap", 16'(ovf_n), 16'd0);
    check("R10 chain low", 16'(chain), 16'd0);
    pulse_hit();
    check("R7 flag sticky", 16'(ovf_n), 16'd0);
    read_val(v);
    check("R7 wrapped value", v, 16'd1);
    check("R7 cleared by shift", 16'(ovf_n), 16'd1);
    ovf_prev = 0; idle(1);
    check("R10 upstream low", 16'(chain), 16'd0);
    ovf_prev = 1; idle(1);
    check("R10 chain high", 16'(chain), 16'd1);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    idle(3); rst_n = 1; idle(4);
    t_reset();
    t_count();
    t_load();
    t_msb();
    t_dir();
    t_ignore();
    t_test_count();
    t_test_read();
    t_spurious();
    t_ovf();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end
endmodule